// File: doc/BRIEF.md
# Buffered Serial Transmitter with Line-Ending Expansion

This block queues bytes from a producer in an eight-slot circular store and sends them on a single line as asynchronous frames: one low start bit, eight data bits with the least significant first, and one high stop bit, with no parity. Each bit lasts a number of clock cycles set by a divisor input. The divisor is the clock frequency divided by the baud rate, so a 48 MHz clock at 9600 baud uses 5000.

As bytes leave the store, the block turns every line feed (0x0A) that does not follow a carriage return (0x0D) into the pair CR, LF. It does this by sending a CR and leaving the LF at the head of the store, so the LF goes out in the next frame. The line-feed check uses the byte most recently placed on the line, and that includes any CR the block inserted.

The producer sees a valid/ready write port. A full flag and an empty flag give simple flow control and an idle indication.

Top module: `uart_tx_crlf`

## Requirements
- R1: After reset, tx_o is high, empty_o is 1, full_o is 0 and wr_ready_o is 1. The last-sent byte register holds 0x00.
- R2: Each byte is sent as one low start bit, then data bits 0 to 7, then one high stop bit. Each bit lasts baud_div_i clock cycles, and a divisor of 0 is treated as 1.
- R3: The store accepts at most 7 queued bytes. When 7 are queued, full_o is 1 and wr_ready_o is 0, and a write offered while full is not taken.
- R4: empty_o is 1 exactly when no byte is queued. When the store is empty and the current frame has finished, tx_o stays high.
- R5: If the head byte is 0x0A and the last byte sent was not 0x0D, the block sends 0x0D and keeps the 0x0A at the head. The 0x0A is sent in the next frame.
- R6: A 0x0A that directly follows a sent 0x0D is sent once, with no extra 0x0D.
- R7: The last-sent register is updated with every byte placed on the line, including an inserted 0x0D. So two line feeds in a row each get their own 0x0D.
- R8: When more bytes are waiting, a new start bit begins on the cycle right after the previous stop bit ends. Back-to-back start bits are therefore exactly 10 × baud_div_i cycles apart.
- R9: Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Producer offers a byte |
| wr_data_i | input | 8 | Byte offered |
| wr_ready_o | output | 1 | Byte is taken when both valid and ready are high |
| baud_div_i | input | 16 | Clock cycles per bit |
| tx_o | output | 1 | Serial line, idles high |
| full_o | output | 1 | Seven bytes queued |
| empty_o | output | 1 | No byte queued |

## Verification
The bench sends several kinds of byte stream:
- Plain bytes with mixed bit patterns separate a wrong bit order from a wrong start or stop level.
- A lone LF sent right after reset shows the inserted CR and the cleared last-sent register.
- A CR followed by an LF shows that no extra CR is added.
- A letter followed by two LFs shows that an inserted CR counts as the last byte sent.
- A burst written faster than the line drains hits the seven-byte limit and shows that the refused write is lost. The same burst shows that order is kept.
- A gap test at two divisors measures the spacing between start bits to catch idle cycles or a wrong bit length.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {SER_IDLE, SER_START, SER_DATA, SER_STOP} ser_state_e;
  localparam logic [7:0] CHAR_CR = 8'h0D;
  localparam logic [7:0] CHAR_LF = 8'h0A;
endpackage

// File: rtl/tx_ring.sv
module tx_ring #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_nxt;

  // one slot is held back so that full and empty differ
  assign wr_nxt  = wr_q + AW'(1);
  assign full_o  = (wr_nxt == rd_q);
  assign empty_o = (wr_q == rd_q);
  assign head_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_nxt;
      if (pop_i)  rd_q <= rd_q + AW'(1);
    end
  end
endmodule

// File: rtl/crlf_sel.sv
module crlf_sel
  import uart_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] head_i,
  input  logic       empty_i,
  input  logic       ser_ready_i,
  output logic       load_o,
  output logic [7:0] byte_o,
  output logic       pop_o,
  output logic [7:0] last_o
);
  logic [7:0] last_q;
  logic       insert_cr;

  assign insert_cr = (head_i == CHAR_LF) && (last_q != CHAR_CR);
  assign load_o    = !empty_i && ser_ready_i;
  assign byte_o    = insert_cr ? CHAR_CR : head_i;
  // inserted CR leaves the LF at the head
  assign pop_o     = load_o && !insert_cr;
  assign last_o    = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (load_o) last_q <= byte_o;
  end
endmodule

// File: rtl/tx_serial.sv
module tx_serial
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic             tx_o
);
  ser_state_e       st_q;
  logic [DIV_W-1:0] cnt_q, div_eff;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             tick;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick    = (cnt_q == div_eff - DIV_W'(1));
  // accepting on the last stop cycle keeps frames gapless
  assign ready_o = (st_q == SER_IDLE) || ((st_q == SER_STOP) && tick);

  always_comb begin
    unique case (st_q)
      SER_START: tx_o = 1'b0;
      SER_DATA:  tx_o = sh_q[0];
      default:   tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SER_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      st_q  <= SER_START;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= data_i;
    end else begin
      unique case (st_q)
        SER_IDLE: cnt_q <= '0;
        SER_START: begin
          if (tick) begin
            st_q  <= SER_DATA;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        SER_DATA: begin
          if (tick) begin
            cnt_q <= '0;
            sh_q  <= {1'b0, sh_q[7:1]};
            if (bit_q == 3'd7) st_q <= SER_STOP;
            else               bit_q <= bit_q + 3'd1;
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        SER_STOP: begin
          if (tick) begin
            st_q  <= SER_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        default: st_q <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_crlf.sv
module uart_tx_crlf #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  input  logic [DIV_W-1:0] baud_div_i,
  output logic             tx_o,
  output logic             full_o,
  output logic             empty_o
);
  logic       fifo_push, fifo_pop, ser_load, ser_ready;
  logic [7:0] head_byte, ser_byte, last_byte;

  assign wr_ready_o = !full_o;
  assign fifo_push  = wr_valid_i && wr_ready_o;

  tx_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  (wr_data_i),
    .pop_i   (fifo_pop),
    .head_o  (head_byte),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  crlf_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_i      (head_byte),
    .empty_i     (empty_o),
    .ser_ready_i (ser_ready),
    .load_o      (ser_load),
    .byte_o      (ser_byte),
    .pop_o       (fifo_pop),
    .last_o      (last_byte)
  );

  tx_serial #(.DIV_W(DIV_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (baud_div_i),
    .load_i  (ser_load),
    .data_i  (ser_byte),
    .ready_o (ser_ready),
    .tx_o    (tx_o)
  );
endmodule

// File: rtl/uart_tx_crlf_chk.sv
module uart_tx_crlf_chk
  import uart_tx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_o,
  input logic       full_o,
  input logic       empty_o,
  input logic       load_i,
  input logic [7:0] byte_i,
  input logic [7:0] head_i,
  input logic       pop_i,
  input logic [7:0] last_i,
  input logic       ser_ready_i
);
  // R3
  full_not_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> !empty_o);
  // R4
  line_high_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_ready_i |-> tx_o);
  // R5
  bare_lf_expand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && head_i == CHAR_LF && last_i != CHAR_CR) |-> (byte_i == CHAR_CR && !pop_i));
  // R6
  lf_after_cr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && byte_i == CHAR_LF) |-> (last_i == CHAR_CR));
  // R7
  last_tracks_sent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (last_i == $past(byte_i)));
  // R9
  pop_only_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (load_i && !empty_o));
endmodule

bind uart_tx_crlf uart_tx_crlf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_o        (tx_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .load_i      (ser_load),
  .byte_i      (ser_byte),
  .head_i      (head_byte),
  .pop_i       (fifo_pop),
  .last_i      (last_byte),
  .ser_ready_i (ser_ready)
);

// File: tb/uart_tx_crlf_test.sv
module uart_tx_crlf_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_ready_o, tx_o, full_o, empty_o;
  logic [15:0] baud_div_i;

  int div_cfg = 4;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] rx_buf [0:255];
  int rx_start [0:255];
  int rx_cnt = 0;
  int frame_err = 0;

  assign baud_div_i = 16'(div_cfg);

  uart_tx_crlf uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_ready_o (wr_ready_o),
    .baud_div_i (baud_div_i),
    .tx_o       (tx_o),
    .full_o     (full_o),
    .empty_o    (empty_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // line monitor: samples each bit at its centre
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && tx_o == 1'b0) begin
        logic [9:0] bits;
        int t0;
        t0 = cyc;
        bits[0] = 1'b0;
        repeat (div_cfg/2) @(negedge clk_i);
        bits[0] = tx_o;
        for (int k = 1; k < 10; k++) begin
          repeat (div_cfg) @(negedge clk_i);
          bits[k] = tx_o;
        end
        if (bits[0] != 1'b0 || bits[9] != 1'b1) frame_err = frame_err + 1;
        rx_buf[rx_cnt[7:0]] = bits[8:1];
        rx_start[rx_cnt[7:0]] = t0;
        rx_cnt = rx_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    wr_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    wr_valid_i = 1'b1;
    wr_data_i = b;
    while (!wr_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 wr_valid_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (!empty_o) @(negedge clk_i);
    repeat (11*div_cfg + 4) @(negedge clk_i);
  endtask

  task automatic expect_seq(input int base, input logic [7:0] exp [], input string req);
    check(rx_cnt - base == exp.size(), req, rx_cnt - base, exp.size());
    for (int i = 0; i < exp.size(); i++)
      if (base + i < rx_cnt)
        check(rx_buf[base+i] == exp[i], req, rx_buf[base+i], exp[i]);
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    check(tx_o == 1'b1, "R1 tx", tx_o, 1);
    check(empty_o == 1'b1 && full_o == 1'b0, "R1 flags", {full_o, empty_o}, 1);
    check(wr_ready_o == 1'b1, "R1 ready", wr_ready_o, 1);
  endtask

  task automatic t_plain();
    int base, fe;
    logic [7:0] exp [];
    div_cfg = 4;
    base = rx_cnt; fe = frame_err;
    push(8'h35); push(8'hA6); push(8'h01);
    drain();
    exp = '{8'h35, 8'hA6, 8'h01};
    expect_seq(base, exp, "R2/R9 plain");
    check(frame_err == fe, "R2 framing", frame_err - fe, 0);
    // R4 idle after drain
    check(tx_o == 1'b1 && empty_o == 1'b1, "R4 idle", {tx_o, empty_o}, 3);
  endtask

  task automatic t_bare_lf();
    int base;
    logic [7:0] exp [];
    do_reset();
    base = rx_cnt;
    push(8'h0A);
    drain();
    exp = '{8'h0D, 8'h0A};
    expect_seq(base, exp, "R5/R1 bare lf after reset");
  endtask

  task automatic t_crlf();
    int base;
    logic [7:0] exp [];
    base = rx_cnt;
    push(8'h0D); push(8'h0A);
    drain();
    exp = '{8'h0D, 8'h0A};
    expect_seq(base, exp, "R6 cr lf");
  endtask

  task automatic t_lf_lf();
    int base;
    logic [7:0] exp [];
    base = rx_cnt;
    push(8'h41); push(8'h0A); push(8'h0A);
    drain();
    exp = '{8'h41, 8'h0D, 8'h0A, 8'h0D, 8'h0A};
    expect_seq(base, exp, "R7 lf lf");
  endtask

  task automatic t_gap(input int d);
    int base;
    div_cfg = d;
    base = rx_cnt;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    drain();
    check(rx_cnt - base == 4, "R8 count", rx_cnt - base, 4);
    for (int i = 1; i < 4; i++)
      if (base + i < rx_cnt)
        check(rx_start[base+i] - rx_start[base+i-1] == 10*d, "R8/R2 spacing",
              rx_start[base+i] - rx_start[base+i-1], 10*d);
  endtask

  task automatic t_full();
    int base, acc;
    logic [7:0] exp [];
    div_cfg = 40;
    base = rx_cnt;
    acc = 0;
    for (int i = 0; i < 20; i++) begin
      logic rdy;
      @(negedge clk_i);
      wr_valid_i = 1'b1;
      wr_data_i = 8'h60 + 8'(acc);
      rdy = wr_ready_o;
      @(posedge clk_i);
      if (rdy) acc++;
    end
    @(negedge clk_i);
    // one byte already on the line, seven queued
    check(acc == 8, "R3 accepted", acc, 8);
    check(full_o == 1'b1 && wr_ready_o == 1'b0, "R3 full", {full_o, wr_ready_o}, 2);
    check(empty_o == 1'b0, "R4 not empty", empty_o, 0);
    wr_valid_i = 1'b0;
    drain();
    exp = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67};
    expect_seq(base, exp, "R3/R9 stalled write dropped");
    check(empty_o == 1'b1 && full_o == 1'b0, "R4 empty after drain", {full_o, empty_o}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_bare_lf();
    t_crlf();
    t_lf_lf();
    t_gap(5);
    t_gap(7);
    t_full();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule